// File: doc/BRIEF.md
# CAN Transmit Request Handoff Unit

This unit sits between the per-object message store of a CAN controller and its frame engine. It holds the identifier, data length code, payload and control flags of each message object. Among the objects that are ready to send, it picks the lowest-numbered one. It copies that object's complete contents into a hidden transmit buffer in a single clock edge and offers the buffer to the frame engine until the engine takes it at start of frame. Bit framing, CRC and bus arbitration are handled elsewhere.

The CPU changes an object through a write port that takes an operation code and an object number. A request is withdrawn when the CPU clears the object's request flag, clears its valid flag, or sets its update-in-progress flag. The unit never commits the buffer in a cycle where such a write hits the candidate object. A withdraw that arrives while the buffer is being offered cancels the offer. The buffer is therefore only ever offered with one object's full contents, and never with the all-zero reset contents that would go out as a remote frame with identifier 0 and length 0.

A controller state machine sequences each handoff. Its states are:
- ST_IDLE: no frame offered.
- ST_LOADED: buffer offered to the engine.
- ST_ONBUS: frame in flight.

Its transitions are:
- ST_IDLE to ST_LOADED: commit.
- ST_LOADED to ST_ONBUS: the engine takes the frame at start of frame.
- ST_LOADED to ST_IDLE: cancel, caused by a withdraw on the held object or by init mode.
- ST_ONBUS to ST_IDLE: the engine reports success, lost arbitration or an error.

Top module: `can_txreq_handoff`

## Requirements
- R1: After reset, `hb_valid` and `tx_done` are 0 and every `newdat` bit is 0.
- R2: An object is eligible when its request flag is set (op 1 sets it), its valid flag is set (op 3 sets it) and its update flag is clear (op 6 clears it). In ST_IDLE the lowest-numbered eligible object is committed. One cycle later, `hb_valid` is 1 and `hb_obj` gives that object's number.
- R3: While `hb_valid` is 1, `hb_id`, `hb_dlc` and `hb_data` equal the committed object's stored contents, `hb_obj` lies in 1..NUM_OBJ, and all of these stay stable.
- R4: A withdraw write names the candidate object. A withdraw is op 2 (clear request), op 4 (clear valid) or op 5 (set update). Such a write in the candidate's commit cycle blocks the commit, and selection is evaluated again in the next cycle.
- R5: A withdraw on the held object while in ST_LOADED, without `fe_sof`, drops `hb_valid` on the next cycle and sends no frame. If `fe_sof` arrives in the same cycle, the frame proceeds with its full contents.
- R6: While `init_mode` is 1, no commit happens, and a loaded buffer is cancelled unless `fe_sof` is high.
- R7: Op 7 writes an object's identifier, length and data and sets its `newdat` bit (bit n-1 for object n). A commit of that object clears the bit.
- R8: When `fe_ok` is asserted in ST_ONBUS, the object's request flag is cleared. On the next cycle, `tx_done` is high for exactly one cycle with `tx_done_obj` set to the object number.
- R9: After `fe_lost` or `fe_err`, the object is offered again if it is still eligible. If it was withdrawn in the meantime, it is not offered again.
- R10: A remote frame received into an object (`rx_rmt_valid`) sets its request flag and leaves its length, identifier and data unchanged.
- R11: Writes naming object 0 or a number above NUM_OBJ have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_mode | input | 1 | Controller in init; no handoff while high |
| cpu_op | input | 3 | Operation: 0 none, 1 set request, 2 clear request, 3 set valid, 4 clear valid, 5 set update, 6 clear update, 7 load contents |
| cpu_obj | input | OBJ_W | Target object number, 1..NUM_OBJ |
| cpu_id | input | ID_W | Identifier for op 7 |
| cpu_dlc | input | DLC_W | Length code for op 7 |
| cpu_data | input | DATA_W | Payload for op 7 |
| rx_rmt_valid | input | 1 | Remote frame received into an object |
| rx_rmt_obj | input | OBJ_W | Object that received the remote frame |
| fe_sof | input | 1 | Engine takes the offered buffer at start of frame |
| fe_ok | input | 1 | Frame sent successfully |
| fe_lost | input | 1 | Frame lost arbitration |
| fe_err | input | 1 | Frame destroyed by an error frame |
| hb_valid | output | 1 | Hidden buffer offered to the engine |
| hb_obj | output | OBJ_W | Object held in the buffer |
| hb_id | output | ID_W | Buffered identifier |
| hb_dlc | output | DLC_W | Buffered length code |
| hb_data | output | DATA_W | Buffered payload |
| tx_done | output | 1 | One-cycle completion pulse |
| tx_done_obj | output | OBJ_W | Object that completed |
| newdat | output | NUM_OBJ | New-data flag for each object |

## Verification
The bench builds the unit with its defaults: 14 objects, 11-bit identifiers, 4-bit length codes and 64-bit payloads. At this size a 4-bit object field reaches both unused codes, 0 and 15, so the R11 ignore cases can be driven directly. Fourteen objects also give the random rounds enough competing requests to exercise lowest-number priority across the whole range. Directed cases line up the narrow races: a withdraw in the commit cycle, a withdraw while the buffer is offered, and a withdraw in the same cycle as start of frame. They also cover retry after lost arbitration and after an error.

// File: rtl/can_txh_pkg.sv
package can_txh_pkg;

    typedef enum logic [2:0] {
        OP_NOP        = 3'd0,
        OP_SET_TXRQ   = 3'd1,
        OP_CLR_TXRQ   = 3'd2,
        OP_SET_MSGVAL = 3'd3,
        OP_CLR_MSGVAL = 3'd4,
        OP_SET_CPUUPD = 3'd5,
        OP_CLR_CPUUPD = 3'd6,
        OP_LOAD       = 3'd7
    } cpu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOADED = 2'd1,
        ST_ONBUS  = 2'd2
    } txh_state_e;

    // A write that takes back a pending request
    function automatic logic is_withdraw(input logic [2:0] op);
        return (op == OP_CLR_TXRQ) || (op == OP_CLR_MSGVAL) || (op == OP_SET_CPUUPD);
    endfunction

endpackage

// File: rtl/can_txh_objstore.sv
module can_txh_objstore
    import can_txh_pkg::*;
#(
    parameter int NUM_OBJ = 14,
    parameter int OBJ_W   = 4,
    parameter int ID_W    = 11,
    parameter int DLC_W   = 4,
    parameter int DATA_W  = 64
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [2:0]                       cpu_op,
    input  logic [OBJ_W-1:0]                 cpu_obj,
    input  logic [ID_W-1:0]                  cpu_id,
    input  logic [DLC_W-1:0]                 cpu_dlc,
    input  logic [DATA_W-1:0]                cpu_data,
    input  logic                             rmt_valid,
    input  logic [OBJ_W-1:0]                 rmt_obj,
    input  logic                             take_valid,
    input  logic [OBJ_W-1:0]                 take_obj,
    input  logic                             done_valid,
    input  logic [OBJ_W-1:0]                 done_obj,
    output logic [NUM_OBJ-1:0]               elig,
    output logic [NUM_OBJ-1:0]               newdat,
    output logic [NUM_OBJ-1:0][ID_W-1:0]     obj_id,
    output logic [NUM_OBJ-1:0][DLC_W-1:0]    obj_dlc,
    output logic [NUM_OBJ-1:0][DATA_W-1:0]   obj_data
);

    for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
        localparam logic [OBJ_W-1:0] MY_NUM = OBJ_W'(g + 1);

        logic txrq_q, msgval_q, cpuupd_q, newdat_q;
        logic cpu_hit;

        assign cpu_hit = (cpu_obj == MY_NUM);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                txrq_q   <= 1'b0;
                msgval_q <= 1'b0;
                cpuupd_q <= 1'b0;
            end else begin
                if (done_valid && done_obj == MY_NUM) txrq_q <= 1'b0;
                if (rmt_valid && rmt_obj == MY_NUM)   txrq_q <= 1'b1;
                if (cpu_hit) begin
                    unique case (cpu_op)
                        OP_SET_TXRQ:   txrq_q   <= 1'b1;
                        OP_CLR_TXRQ:   txrq_q   <= 1'b0;
                        OP_SET_MSGVAL: msgval_q <= 1'b1;
                        OP_CLR_MSGVAL: msgval_q <= 1'b0;
                        OP_SET_CPUUPD: cpuupd_q <= 1'b1;
                        OP_CLR_CPUUPD: cpuupd_q <= 1'b0;
                        default: ;
                    endcase
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                newdat_q <= 1'b0;
            end else if (cpu_hit && cpu_op == OP_LOAD) begin
                newdat_q <= 1'b1;
            end else if (take_valid && take_obj == MY_NUM) begin
                newdat_q <= 1'b0;
            end
        end

        // Contents change only on a CPU load; a received remote frame leaves them
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                obj_id[g]   <= '0;
                obj_dlc[g]  <= '0;
                obj_data[g] <= '0;
            end else if (cpu_hit && cpu_op == OP_LOAD) begin
                obj_id[g]   <= cpu_id;
                obj_dlc[g]  <= cpu_dlc;
                obj_data[g] <= cpu_data;
            end
        end

        assign elig[g]   = txrq_q && msgval_q && !cpuupd_q;
        assign newdat[g] = newdat_q;
    end

endmodule

// File: rtl/can_txh_picker.sv
module can_txh_picker #(
    parameter int NUM_OBJ = 14,
    parameter int OBJ_W   = 4
) (
    input  logic [NUM_OBJ-1:0] elig,
    output logic               found,
    output logic [OBJ_W-1:0]   pick_obj
);

    // Scan downward so the lowest-numbered eligible object is written last and wins
    always_comb begin
        found    = 1'b0;
        pick_obj = '0;
        for (int i = NUM_OBJ - 1; i >= 0; i--) begin
            if (elig[i]) begin
                found    = 1'b1;
                pick_obj = OBJ_W'(i + 1);
            end
        end
    end

endmodule

// File: rtl/can_txh_hbuf.sv
module can_txh_hbuf #(
    parameter int NUM_OBJ = 14,
    parameter int OBJ_W   = 4,
    parameter int ID_W    = 11,
    parameter int DLC_W   = 4,
    parameter int DATA_W  = 64
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             load,
    input  logic [OBJ_W-1:0]                 sel_obj,
    input  logic [NUM_OBJ-1:0][ID_W-1:0]     obj_id,
    input  logic [NUM_OBJ-1:0][DLC_W-1:0]    obj_dlc,
    input  logic [NUM_OBJ-1:0][DATA_W-1:0]   obj_data,
    output logic [OBJ_W-1:0]                 buf_obj,
    output logic [ID_W-1:0]                  buf_id,
    output logic [DLC_W-1:0]                 buf_dlc,
    output logic [DATA_W-1:0]                buf_data
);

    logic [ID_W-1:0]   mux_id;
    logic [DLC_W-1:0]  mux_dlc;
    logic [DATA_W-1:0] mux_data;

    always_comb begin
        mux_id   = '0;
        mux_dlc  = '0;
        mux_data = '0;
        for (int i = 0; i < NUM_OBJ; i++) begin
            if (sel_obj == OBJ_W'(i + 1)) begin
                mux_id   = obj_id[i];
                mux_dlc  = obj_dlc[i];
                mux_data = obj_data[i];
            end
        end
    end

    // Number, identifier, length and data all enter on the same edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_obj  <= '0;
            buf_id   <= '0;
            buf_dlc  <= '0;
            buf_data <= '0;
        end else if (load) begin
            buf_obj  <= sel_obj;
            buf_id   <= mux_id;
            buf_dlc  <= mux_dlc;
            buf_data <= mux_data;
        end
    end

endmodule

// File: rtl/can_txreq_handoff.sv
module can_txreq_handoff
    import can_txh_pkg::*;
#(
    parameter int NUM_OBJ = 14,
    parameter int ID_W    = 11,
    parameter int DLC_W   = 4,
    parameter int DATA_W  = 64,
    localparam int OBJ_W  = $clog2(NUM_OBJ + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                init_mode,
    input  logic [2:0]          cpu_op,
    input  logic [OBJ_W-1:0]    cpu_obj,
    input  logic [ID_W-1:0]     cpu_id,
    input  logic [DLC_W-1:0]    cpu_dlc,
    input  logic [DATA_W-1:0]   cpu_data,
    input  logic                rx_rmt_valid,
    input  logic [OBJ_W-1:0]    rx_rmt_obj,
    input  logic                fe_sof,
    input  logic                fe_ok,
    input  logic                fe_lost,
    input  logic                fe_err,
    output logic                hb_valid,
    output logic [OBJ_W-1:0]    hb_obj,
    output logic [ID_W-1:0]     hb_id,
    output logic [DLC_W-1:0]    hb_dlc,
    output logic [DATA_W-1:0]   hb_data,
    output logic                tx_done,
    output logic [OBJ_W-1:0]    tx_done_obj,
    output logic [NUM_OBJ-1:0]  newdat
);

    txh_state_e state_q, state_d;

    logic [NUM_OBJ-1:0]             elig;
    logic [NUM_OBJ-1:0][ID_W-1:0]   obj_id;
    logic [NUM_OBJ-1:0][DLC_W-1:0]  obj_dlc;
    logic [NUM_OBJ-1:0][DATA_W-1:0] obj_data;
    logic                           found;
    logic [OBJ_W-1:0]               pick_obj;
    logic                           wd_write;
    logic                           commit;
    logic                           held_hit;
    logic                           done_valid;

    assign wd_write = is_withdraw(cpu_op);
    assign commit   = (state_q == ST_IDLE) && !init_mode && found &&
                      !(wd_write && cpu_obj == pick_obj);
    assign held_hit = wd_write && (cpu_obj == hb_obj);

    can_txh_objstore #(
        .NUM_OBJ(NUM_OBJ), .OBJ_W(OBJ_W), .ID_W(ID_W), .DLC_W(DLC_W), .DATA_W(DATA_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_op     (cpu_op),
        .cpu_obj    (cpu_obj),
        .cpu_id     (cpu_id),
        .cpu_dlc    (cpu_dlc),
        .cpu_data   (cpu_data),
        .rmt_valid  (rx_rmt_valid),
        .rmt_obj    (rx_rmt_obj),
        .take_valid (commit),
        .take_obj   (pick_obj),
        .done_valid (done_valid),
        .done_obj   (hb_obj),
        .elig       (elig),
        .newdat     (newdat),
        .obj_id     (obj_id),
        .obj_dlc    (obj_dlc),
        .obj_data   (obj_data)
    );

    can_txh_picker #(.NUM_OBJ(NUM_OBJ), .OBJ_W(OBJ_W)) u_pick (
        .elig     (elig),
        .found    (found),
        .pick_obj (pick_obj)
    );

    can_txh_hbuf #(
        .NUM_OBJ(NUM_OBJ), .OBJ_W(OBJ_W), .ID_W(ID_W), .DLC_W(DLC_W), .DATA_W(DATA_W)
    ) u_hbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (commit),
        .sel_obj  (pick_obj),
        .obj_id   (obj_id),
        .obj_dlc  (obj_dlc),
        .obj_data (obj_data),
        .buf_obj  (hb_obj),
        .buf_id   (hb_id),
        .buf_dlc  (hb_dlc),
        .buf_data (hb_data)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (commit) state_d = ST_LOADED;
            ST_LOADED: begin
                if (fe_sof)                     state_d = ST_ONBUS;
                else if (init_mode || held_hit) state_d = ST_IDLE;
            end
            ST_ONBUS:  if (fe_ok || fe_lost || fe_err) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        hb_valid   = (state_q == ST_LOADED);
        done_valid = (state_q == ST_ONBUS) && fe_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_done     <= 1'b0;
            tx_done_obj <= '0;
        end else begin
            tx_done     <= done_valid;
            tx_done_obj <= done_valid ? hb_obj : '0;
        end
    end

endmodule

// File: rtl/can_txh_chk.sv
module can_txh_chk #(
    parameter int NUM_OBJ = 14,
    parameter int ID_W    = 11,
    parameter int DLC_W   = 4,
    parameter int DATA_W  = 64,
    localparam int OBJ_W  = $clog2(NUM_OBJ + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              init_mode,
    input logic [2:0]        cpu_op,
    input logic [OBJ_W-1:0]  cpu_obj,
    input logic              fe_sof,
    input logic              hb_valid,
    input logic [OBJ_W-1:0]  hb_obj,
    input logic [ID_W-1:0]   hb_id,
    input logic [DLC_W-1:0]  hb_dlc,
    input logic [DATA_W-1:0] hb_data,
    input logic              tx_done,
    input logic [OBJ_W-1:0]  tx_done_obj
);

    logic wd_now;
    assign wd_now = (cpu_op == 3'd2) || (cpu_op == 3'd4) || (cpu_op == 3'd5);

    AST_NO_INIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hb_valid) |-> !$past(init_mode)); // R6

    AST_NO_WITHDRAWN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hb_valid) |-> !($past(wd_now) && $past(cpu_obj) == hb_obj)); // R4

    AST_OBJ_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        hb_valid |-> (hb_obj >= OBJ_W'(1) && hb_obj <= OBJ_W'(NUM_OBJ))); // R3

    AST_BUF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hb_valid) && hb_valid) |-> ($stable(hb_id) && $stable(hb_dlc) && $stable(hb_data) && $stable(hb_obj))); // R3

    AST_WITHDRAW_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_valid && !fe_sof && wd_now && cpu_obj == hb_obj) |=> !hb_valid); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done); // R8

    AST_DONE_OBJ_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (tx_done_obj >= OBJ_W'(1) && tx_done_obj <= OBJ_W'(NUM_OBJ))); // R8

endmodule

bind can_txreq_handoff can_txh_chk #(
    .NUM_OBJ(NUM_OBJ), .ID_W(ID_W), .DLC_W(DLC_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/can_txreq_handoff_tb.sv
module can_txreq_handoff_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NOBJ = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_mode = 1'b1;
    logic [2:0]  cpu_op = '0;
    logic [3:0]  cpu_obj = '0;
    logic [10:0] cpu_id = '0;
    logic [3:0]  cpu_dlc = '0;
    logic [63:0] cpu_data = '0;
    logic        rx_rmt_valid = 1'b0;
    logic [3:0]  rx_rmt_obj = '0;
    logic        fe_sof = 1'b0, fe_ok = 1'b0, fe_lost = 1'b0, fe_err = 1'b0;
    logic        hb_valid;
    logic [3:0]  hb_obj;
    logic [10:0] hb_id;
    logic [3:0]  hb_dlc;
    logic [63:0] hb_data;
    logic        tx_done;
    logic [3:0]  tx_done_obj;
    logic [13:0] newdat;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    bit          m_tx[16], m_val[16], m_upd[16], m_nd[16];
    logic [10:0] m_id[16];
    logic [3:0]  m_dlc[16];
    logic [63:0] m_data[16];

    always #(CLK_PERIOD/2) clk = ~clk;

    can_txreq_handoff u_dut (
        .clk(clk), .rst_n(rst_n), .init_mode(init_mode),
        .cpu_op(cpu_op), .cpu_obj(cpu_obj), .cpu_id(cpu_id), .cpu_dlc(cpu_dlc), .cpu_data(cpu_data),
        .rx_rmt_valid(rx_rmt_valid), .rx_rmt_obj(rx_rmt_obj),
        .fe_sof(fe_sof), .fe_ok(fe_ok), .fe_lost(fe_lost), .fe_err(fe_err),
        .hb_valid(hb_valid), .hb_obj(hb_obj), .hb_id(hb_id), .hb_dlc(hb_dlc), .hb_data(hb_data),
        .tx_done(tx_done), .tx_done_obj(tx_done_obj), .newdat(newdat)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_pick();
        for (int i = 1; i <= NOBJ; i++)
            if (m_tx[i] && m_val[i] && !m_upd[i]) return i;
        return 0;
    endfunction

    function automatic logic [13:0] exp_newdat();
        logic [13:0] v;
        for (int i = 1; i <= NOBJ; i++) v[i-1] = m_nd[i];
        return v;
    endfunction

    // Applied on one clock edge; call at a falling edge, returns at the next one
    task automatic op(input int o, input int n, input logic [10:0] id = '0,
                      input logic [3:0] dlc = '0, input logic [63:0] data = '0);
        cpu_op = 3'(o); cpu_obj = 4'(n); cpu_id = id; cpu_dlc = dlc; cpu_data = data;
        @(negedge clk);
        cpu_op = '0; cpu_obj = '0;
        if (n >= 1 && n <= NOBJ) begin
            case (o)
                1: m_tx[n] = 1'b1;
                2: m_tx[n] = 1'b0;
                3: m_val[n] = 1'b1;
                4: m_val[n] = 1'b0;
                5: m_upd[n] = 1'b1;
                6: m_upd[n] = 1'b0;
                7: begin m_id[n] = id; m_dlc[n] = dlc; m_data[n] = data; m_nd[n] = 1'b1; end
                default: ;
            endcase
        end
    endtask

    task automatic check_handoff(input int n, input string req);
        chk(hb_valid == 1'b1, req, "hb_valid", 64'(hb_valid), 64'd1);
        chk(hb_obj == 4'(n), req, "hb_obj", 64'(hb_obj), 64'(n));
        chk(hb_id == m_id[n], req, "hb_id", 64'(hb_id), 64'(m_id[n]));
        chk(hb_dlc == m_dlc[n], req, "hb_dlc", 64'(hb_dlc), 64'(m_dlc[n]));
        chk(hb_data == m_data[n], req, "hb_data", hb_data, m_data[n]);
        m_nd[n] = 1'b0;
        chk(newdat == exp_newdat(), "R7", "newdat after commit", 64'(newdat), 64'(exp_newdat()));
    endtask

    task automatic finish_frame(input int n);
        fe_sof = 1'b1; @(negedge clk); fe_sof = 1'b0;
        fe_ok = 1'b1;  @(negedge clk); fe_ok = 1'b0;
        chk(tx_done == 1'b1, "R8", "tx_done", 64'(tx_done), 64'd1);
        chk(tx_done_obj == 4'(n), "R8", "tx_done_obj", 64'(tx_done_obj), 64'(n));
        m_tx[n] = 1'b0;
    endtask

    task automatic lose_frame(input bit use_err);
        fe_sof = 1'b1; @(negedge clk); fe_sof = 1'b0;
        if (use_err) fe_err = 1'b1; else fe_lost = 1'b1;
        @(negedge clk); fe_err = 1'b0; fe_lost = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 16; i++) begin
            m_tx[i] = 0; m_val[i] = 0; m_upd[i] = 0; m_nd[i] = 0;
            m_id[i] = '0; m_dlc[i] = '0; m_data[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(hb_valid == 1'b0, "R1", "hb_valid", 64'(hb_valid), 64'd0);
        chk(tx_done == 1'b0, "R1", "tx_done", 64'(tx_done), 64'd0);
        chk(newdat == '0, "R1", "newdat", 64'(newdat), 64'd0);

        // Configure under init: objects 5 and 3 pending
        op(7, 5, 11'h2A5, 4'd8, 64'hDEAD_BEEF_0123_4567);
        op(7, 3, 11'h133, 4'd2, 64'h0000_0000_0000_A5A5);
        op(3, 5); op(3, 3); op(1, 5); op(1, 3);
        repeat (3) @(negedge clk);
        chk(hb_valid == 1'b0, "R6", "no handoff in init", 64'(hb_valid), 64'd0);
        chk(newdat == exp_newdat(), "R7", "newdat set by load", 64'(newdat), 64'(exp_newdat()));

        // R2 lowest-numbered wins
        init_mode = 1'b0;
        @(negedge clk);
        check_handoff(3, "R2");

        // R5 withdraw while offered cancels, then R2 next object
        op(2, 3);
        chk(hb_valid == 1'b0, "R5", "cancel on withdraw", 64'(hb_valid), 64'd0);
        @(negedge clk);
        check_handoff(5, "R2");
        finish_frame(5);
        @(negedge clk);
        chk(tx_done == 1'b0, "R8", "pulse one cycle", 64'(tx_done), 64'd0);
        repeat (2) @(negedge clk);
        chk(hb_valid == 1'b0, "R8", "request cleared after send", 64'(hb_valid), 64'd0);

        // R4 withdraw in the commit cycle
        init_mode = 1'b1;
        op(7, 7, 11'h7F0, 4'd5, 64'h1111_2222_3333_4444);
        op(3, 7); op(1, 7); op(1, 3);
        init_mode = 1'b0;
        op(5, 3);
        chk(hb_valid == 1'b0, "R4", "no commit on withdraw", 64'(hb_valid), 64'd0);
        @(negedge clk);
        check_handoff(7, "R4");

        // R9 retry after lost arbitration
        lose_frame(1'b0);
        @(negedge clk);
        check_handoff(7, "R9");
        // R9 withdraw in flight, then error: no retry
        fe_sof = 1'b1; @(negedge clk); fe_sof = 1'b0;
        op(2, 7);
        fe_err = 1'b1; @(negedge clk); fe_err = 1'b0;
        repeat (3) @(negedge clk);
        chk(hb_valid == 1'b0, "R9", "no retry after withdraw", 64'(hb_valid), 64'd0);

        // R5 withdraw coinciding with start of frame: frame goes out whole
        op(6, 3);
        @(negedge clk);
        check_handoff(3, "R5");
        fe_sof = 1'b1; cpu_op = 3'd4; cpu_obj = 4'd3;
        @(negedge clk);
        fe_sof = 1'b0; cpu_op = '0; cpu_obj = '0; m_val[3] = 1'b0;
        chk(hb_valid == 1'b0, "R5", "taken at sof", 64'(hb_valid), 64'd0);
        fe_ok = 1'b1; @(negedge clk); fe_ok = 1'b0;
        chk(tx_done == 1'b1 && tx_done_obj == 4'd3, "R5", "sent despite withdraw",
            64'(tx_done_obj), 64'd3);
        m_tx[3] = 1'b0;

        // R10 remote frame sets request, keeps length
        init_mode = 1'b1;
        op(3, 3);
        rx_rmt_valid = 1'b1; rx_rmt_obj = 4'd3;
        @(negedge clk);
        rx_rmt_valid = 1'b0; rx_rmt_obj = '0; m_tx[3] = 1'b1;
        init_mode = 1'b0;
        @(negedge clk);
        check_handoff(3, "R10");
        finish_frame(3);

        // R11 out-of-range object numbers ignored
        init_mode = 1'b1;
        op(1, 0); op(3, 0);
        op(7, 15, 11'h555, 4'd7, 64'hFFFF);
        op(3, 15); op(1, 15);
        chk(newdat == exp_newdat(), "R11", "newdat untouched", 64'(newdat), 64'(exp_newdat()));
        init_mode = 1'b0;
        repeat (3) @(negedge clk);
        chk(hb_valid == 1'b0, "R11", "no handoff", 64'(hb_valid), 64'd0);

        // Random rounds
        for (int r = 0; r < 3; r++) begin
            init_mode = 1'b1;
            for (int n = 1; n <= NOBJ; n++) begin
                op(7, n, 11'($urandom), 4'($urandom % 9), {$urandom, $urandom});
                op(6, n);
                op(($urandom % 4 != 0) ? 3 : 4, n);
                op(($urandom % 3 != 0) ? 1 : 2, n);
                if ($urandom % 5 == 0) op(5, n);
            end
            init_mode = 1'b0;
            for (int k = 0; k < 40; k++) begin
                int e;
                @(negedge clk);
                e = exp_pick();
                if (e == 0) begin
                    chk(hb_valid == 1'b0, "R2", "idle when none eligible", 64'(hb_valid), 64'd0);
                    break;
                end
                check_handoff(e, "R2");
                if ($urandom % 4 == 0) lose_frame(1'($urandom % 2));
                else finish_frame(e);
            end
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule